// File: doc/BRIEF.md
# Quadrature Counter with Index Reload

This block tracks the position of a rotary or linear encoder. It decodes two square waves that are 90 degrees apart (phases A and B). Every edge on either phase is one count, so each full encoder cycle gives four counts. The 16-bit count runs freely. It wraps at both ends and raises a one-cycle flag whenever it crosses the 0xFFFF/0x0000 boundary in either direction.

A third input, the index (Z) mark, can snap the count back to a known position. While index handling is enabled, an edge of the selected polarity on Z arms a pending flag. The next count-source strobe (`tick`) then loads the count from `reload_val`. A value of zero gives a true clear. Every wrap and every index load asks for an interrupt. When a wrap and an index load land on the same clock, the interrupt line stays high for two consecutive cycles, one pulse for each event.

All three encoder inputs are asynchronous to `clk`. Each passes through a two-flop synchroniser before its edges are looked at.

Top module: `quad_index_counter`

## Requirements
- R1: While reset is held and directly after it is released, `count` is 0 and `wrap_flag` and `irq` are 0. No index event is pending.
- R2: With A leading B, the {A,B} sequence 00→10→11→01→00 counts up by one on every phase edge. The new count appears on the third rising clock edge after the input change.
- R3: With B leading A, the sequence 00→01→11→10→00 counts down by one on every phase edge, with the same latency as R2.
- R4: A and B changing together in the same synchroniser sample is not a valid step. The count does not change.
- R5: A step up from 0xFFFF gives 0x0000 (overflow). A step down from 0x0000 gives 0xFFFF (underflow). Either one raises `wrap_flag` for exactly one cycle and `irq` for one cycle, both in the cycle the new count appears.
- R6: `index_rise`=1 makes a rising Z edge the index event, and `index_rise`=0 makes a falling Z edge the index event. The opposite edge is ignored.
- R7: A pending index event loads `count` with `reload_val` on the first clock edge where `tick`=1. A quadrature step landing on that same edge is discarded. Counting then continues from the loaded value, and the pending event is consumed by the load.
- R8: With `index_en`=0, Z edges are not recorded. Dropping `index_en` clears an event that is already pending.
- R9: An index load raises `irq` for one cycle, in the cycle the loaded value appears.
- R10: If a wrap and an index load occur on the same clock edge, `count` takes `reload_val`. `wrap_flag` pulses once, and `irq` is high for two consecutive cycles and then low.
- R11: Without a `tick`, a pending index event is held indefinitely while the quadrature counting carries on normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| phase_a | input | 1 | Encoder phase A, asynchronous |
| phase_b | input | 1 | Encoder phase B, asynchronous |
| index_z | input | 1 | Encoder index mark, asynchronous |
| tick | input | 1 | Count-source strobe; a pending index load happens on it |
| index_en | input | 1 | 1 lets Z edges arm an index load |
| index_rise | input | 1 | 1 selects the rising Z edge, 0 the falling one |
| reload_val | input | 16 | Value loaded by an index event |
| count | output | 16 | Current count |
| wrap_flag | output | 1 | One-cycle pulse on overflow or underflow |
| irq | output | 1 | Interrupt request, one cycle per wrap or index load |

## Verification
Phase and index changes pass through two synchroniser flops and one edge register. A phase change driven just after a falling clock edge therefore shows on `count` after the third rising edge, and the bench samples on the third falling edge after driving. One check samples at the second falling edge to show the count has not yet moved. An index edge arms the pending flag with the same three-edge latency. The load then lands on the first rising edge with `tick` high, and the bench checks `count`, `wrap_flag` and `irq` on the falling edge after it. It checks `irq` again on each of the next two falling edges, which shows a single pulse after a lone event and two back-to-back cycles after a coincident wrap and load.

// File: rtl/qic_pkg.sv
package qic_pkg;
  // One decoded quadrature step: valid when exactly one phase moved.
  typedef struct packed {
    logic valid;
    logic up;
  } qstep_t;

  localparam int unsigned SYNC_STAGES_DEF = 2;
endpackage

// File: rtl/qic_sync.sv
module qic_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[i] <= '0;
        else        stage_q[i] <= d;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[i] <= '0;
        else        stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/qic_quad_dec.sv
module qic_quad_dec
  import qic_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   a,
  input  logic   b,
  output qstep_t step
);
  logic a_prev, b_prev;
  logic a_moved, b_moved;

  always_comb begin
    a_moved    = a ^ a_prev;
    b_moved    = b ^ b_prev;
    step.valid = a_moved ^ b_moved;
    // Gray order 00,10,11,01: new A differing from old B means forward.
    step.up    = a ^ b_prev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_prev <= 1'b0;
      b_prev <= 1'b0;
    end else begin
      a_prev <= a;
      b_prev <= b;
    end
  end
endmodule

// File: rtl/qic_index.sv
module qic_index (
  input  logic clk,
  input  logic rst_n,
  input  logic z,
  input  logic index_en,
  input  logic index_rise,
  input  logic tick,
  output logic pending,
  output logic fire
);
  logic z_prev;
  logic z_edge;
  logic pending_nxt;

  always_comb begin
    z_edge = index_rise ? (z & ~z_prev) : (~z & z_prev);
    fire   = tick & pending & index_en;
    if (!index_en)   pending_nxt = 1'b0;
    else if (z_edge) pending_nxt = 1'b1;
    else if (fire)   pending_nxt = 1'b0;
    else             pending_nxt = pending;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      z_prev  <= 1'b0;
      pending <= 1'b0;
    end else begin
      z_prev  <= z;
      pending <= pending_nxt;
    end
  end
endmodule

// File: rtl/qic_core.sv
module qic_core
  import qic_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  qstep_t           step,
  input  logic             fire,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] count,
  output logic             wrap_evt,
  output logic             wrap_flag,
  output logic             irq
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam int unsigned      OWED_W  = 2;

  logic [CNT_W-1:0]  count_nxt;
  logic [OWED_W-1:0] owed, owed_nxt;
  logic [OWED_W:0]   owed_sum;
  logic              count_en;

  always_comb begin
    wrap_evt = step.valid &
               ((step.up & (count == CNT_MAX)) | (~step.up & (count == '0)));
    count_en = fire | step.valid;
    if (fire)         count_nxt = reload_val;
    else if (step.up) count_nxt = count + CNT_W'(1);
    else              count_nxt = count - CNT_W'(1);

    // One owed interrupt cycle per event; one is paid out each cycle.
    owed_sum = {1'b0, owed} - {{OWED_W{1'b0}}, (owed != '0)}
             + {{OWED_W{1'b0}}, wrap_evt} + {{OWED_W{1'b0}}, fire};
    owed_nxt = owed_sum[OWED_W] ? {OWED_W{1'b1}} : owed_sum[OWED_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count <= '0;
    else if (count_en) count <= count_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrap_flag <= 1'b0;
      owed      <= '0;
    end else begin
      wrap_flag <= wrap_evt;
      owed      <= owed_nxt;
    end
  end

  assign irq = (owed != '0);
endmodule

// File: rtl/quad_index_counter.sv
module quad_index_counter
  import qic_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             phase_a,
  input  logic             phase_b,
  input  logic             index_z,
  input  logic             tick,
  input  logic             index_en,
  input  logic             index_rise,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] count,
  output logic             wrap_flag,
  output logic             irq
);
  localparam int unsigned RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_sn;
  logic [2:0]            pins_s;
  qstep_t                step;
  logic                  pending;
  logic                  fire;
  logic                  wrap_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
  end
  assign rst_sn = rst_pipe[RST_STAGES-1];

  qic_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_sn),
    .d     ({index_z, phase_b, phase_a}),
    .q     (pins_s)
  );

  qic_quad_dec u_dec (
    .clk   (clk),
    .rst_n (rst_sn),
    .a     (pins_s[0]),
    .b     (pins_s[1]),
    .step  (step)
  );

  qic_index u_idx (
    .clk        (clk),
    .rst_n      (rst_sn),
    .z          (pins_s[2]),
    .index_en   (index_en),
    .index_rise (index_rise),
    .tick       (tick),
    .pending    (pending),
    .fire       (fire)
  );

  qic_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_sn),
    .step       (step),
    .fire       (fire),
    .reload_val (reload_val),
    .count      (count),
    .wrap_evt   (wrap_evt),
    .wrap_flag  (wrap_flag),
    .irq        (irq)
  );
endmodule

// File: rtl/qic_checker.sv
module qic_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_sn,
  input logic             index_en,
  input logic [CNT_W-1:0] reload_val,
  input logic [CNT_W-1:0] count,
  input logic             wrap_flag,
  input logic             irq,
  input logic             pending,
  input logic             fire,
  input logic             wrap_evt,
  input logic             step_valid
);
  AST_RELOAD_LOADS: assert property (@(posedge clk) disable iff (!rst_sn)
    fire |=> count == $past(reload_val)); // R7

  AST_INDEX_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_sn)
    !index_en |=> !pending); // R8

  AST_WRAP_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_sn)
    wrap_flag |-> irq); // R5

  AST_DOUBLE_IRQ: assert property (@(posedge clk) disable iff (!rst_sn)
    (fire && wrap_evt) |=> irq ##1 irq); // R10

  AST_LOAD_IRQ: assert property (@(posedge clk) disable iff (!rst_sn)
    fire |=> irq); // R9

  AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_sn)
    !fire |=> (count == $past(count)) || (count == $past(count) + CNT_W'(1))
              || (count == $past(count) - CNT_W'(1))); // R2

  AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (!rst_sn)
    (!step_valid && !fire) |=> $stable(count)); // R4
endmodule

bind quad_index_counter qic_checker #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_sn     (rst_sn),
  .index_en   (index_en),
  .reload_val (reload_val),
  .count      (count),
  .wrap_flag  (wrap_flag),
  .irq        (irq),
  .pending    (pending),
  .fire       (fire),
  .wrap_evt   (wrap_evt),
  .step_valid (step.valid)
);

// File: tb/sim_quad_index_counter.sv
module sim_quad_index_counter;
  logic        clk = 1'b0;
  logic        rst_n, phase_a, phase_b, index_z, tick, index_en, index_rise;
  logic [15:0] reload_val, count;
  logic        wrap_flag, irq;
  int          n_tests = 0;
  int          n_fail  = 0;
  bit          done    = 1'b0;
  logic [15:0] exp_cnt;

  always #10 clk = ~clk;

  quad_index_counter u0 (
    .clk(clk), .rst_n(rst_n), .phase_a(phase_a), .phase_b(phase_b),
    .index_z(index_z), .tick(tick), .index_en(index_en),
    .index_rise(index_rise), .reload_val(reload_val),
    .count(count), .wrap_flag(wrap_flag), .irq(irq)
  );

  // {a, b, move}: move 1 = up, 2 = down, 0 = no count
  localparam logic [3:0] VEC [12] = '{
    4'b1001, 4'b1101, 4'b0101, 4'b0001,
    4'b0110, 4'b1110, 4'b1010, 4'b0010,
    4'b1100, 4'b0000, 4'b1001, 4'b0010
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_ab(input logic a, input logic b);
    phase_a = a; phase_b = b;
    wait_n(3);
  endtask

  task automatic pulse_tick();
    tick = 1'b1;
    wait_n(1);
    tick = 1'b0;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; phase_a = 1'b0; phase_b = 1'b0; index_z = 1'b0;
    tick = 1'b0; index_en = 1'b0; index_rise = 1'b1; reload_val = 16'h0000;
    wait_n(3);
    chk("R1 count in reset", count, 0);
    chk("R1 wrap in reset", wrap_flag, 0);
    chk("R1 irq in reset", irq, 0);
    rst_n = 1'b1;
    wait_n(4);
    chk("R1 count after release", count, 0);
    chk("R1 irq after release", irq, 0);

    // latency: not yet at second edge, present at third
    exp_cnt = 16'h0000;
    for (int i = 0; i < 12; i++) begin
      phase_a = VEC[i][3]; phase_b = VEC[i][2];
      if (i == 0) begin
        wait_n(2);
        chk("R2 count before third edge", count, 0);
        wait_n(1);
      end else begin
        wait_n(3);
      end
      case (VEC[i][1:0])
        2'd1: begin exp_cnt = exp_cnt + 16'd1; chk("R2 up step", count, exp_cnt); end
        2'd2: begin exp_cnt = exp_cnt - 16'd1; chk("R3 down step", count, exp_cnt); end
        default: chk("R4 both phases moved", count, exp_cnt);
      endcase
    end

    // underflow then overflow
    drive_ab(1'b0, 1'b1);
    chk("R5 underflow count", count, 16'hFFFF);
    chk("R5 underflow flag", wrap_flag, 1);
    chk("R5 underflow irq", irq, 1);
    wait_n(1);
    chk("R5 flag one cycle", wrap_flag, 0);
    chk("R5 irq one cycle", irq, 0);
    drive_ab(1'b0, 1'b0);
    chk("R5 overflow count", count, 16'h0000);
    chk("R5 overflow flag", wrap_flag, 1);
    chk("R5 overflow irq", irq, 1);

    // rising index, held without tick
    index_en = 1'b1; index_rise = 1'b1; reload_val = 16'h0005;
    drive_ab(1'b1, 1'b0);
    index_z = 1'b1;
    wait_n(5);
    chk("R11 pending holds, no load", count, 16'h0001);
    drive_ab(1'b1, 1'b1);
    chk("R11 counting while pending", count, 16'h0002);
    pulse_tick();
    chk("R7 load on tick", count, 16'h0005);
    chk("R9 load irq", irq, 1);
    wait_n(1);
    chk("R9 load irq one cycle", irq, 0);
    pulse_tick();
    chk("R7 pending consumed", count, 16'h0005);
    drive_ab(1'b0, 1'b1);
    chk("R7 counts on from load", count, 16'h0006);

    // falling polarity
    index_rise = 1'b0; reload_val = 16'h0007;
    index_z = 1'b0;
    wait_n(3);
    pulse_tick();
    chk("R6 falling edge loads", count, 16'h0007);
    reload_val = 16'h0009;
    index_z = 1'b1;
    wait_n(3);
    pulse_tick();
    chk("R6 rising ignored when falling chosen", count, 16'h0007);

    // index disabled
    index_rise = 1'b1; index_en = 1'b0;
    index_z = 1'b0; wait_n(3);
    index_z = 1'b1; wait_n(3);
    pulse_tick();
    chk("R8 disabled edge ignored", count, 16'h0007);
    index_en = 1'b1;
    index_z = 1'b0; wait_n(3);
    index_z = 1'b1; wait_n(3);
    index_en = 1'b0; wait_n(1);
    index_en = 1'b1;
    pulse_tick();
    chk("R8 disable clears pending", count, 16'h0007);

    // wrap and load on the same edge
    reload_val = 16'hFFFF;
    index_z = 1'b0; wait_n(3);
    index_z = 1'b1; wait_n(3);
    pulse_tick();
    chk("R7 load all ones", count, 16'hFFFF);
    wait_n(1);
    reload_val = 16'h0000;
    index_z = 1'b0; wait_n(3);
    index_z = 1'b1; wait_n(3);
    phase_a = 1'b0; phase_b = 1'b0;
    wait_n(2);
    pulse_tick();
    chk("R10 load wins over step", count, 16'h0000);
    chk("R10 wrap flag", wrap_flag, 1);
    chk("R10 first irq cycle", irq, 1);
    wait_n(1);
    chk("R10 second irq cycle", irq, 1);
    chk("R10 wrap flag single", wrap_flag, 0);
    wait_n(1);
    chk("R10 irq ends", irq, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule